// File: doc/BRIEF.md
# Paged Interrupt Priority Arbiter

This block arbitrates among 128 interrupt request lines. Each line has a 3-bit priority level. Every cycle the block picks one winner from the lines that are pending and enabled. It presents the winner's vector number and level as registered outputs, together with a request flag. The flag is gated by a current-level input, so a handler running at some level is interrupted only by work that is strictly more urgent.

The priority table is never exposed as one flat space. A page register chooses a group of eight consecutive vectors, and eight slot registers then give read and write access to the levels of those eight vectors. The page register holds bits 6:3 of a vector number, and the slot index supplies bits 2:0. To configure vectors that live in different groups, software must rewrite the page register between the accesses.

Top module: `irq_paged_arb`

## Requirements
- R1: After a synchronous active-low reset, every vector's level is 1, the page register reads 0, and irq_req, irq_vec and irq_lvl are all 0.
- R2: A write with cfg_sel = 8 stores cfg_wdata[6:3] as the page and ignores cfg_wdata[7] and cfg_wdata[2:0]. A read with cfg_sel = 8 returns {1'b0, page, 3'b000}.
- R3: A write with cfg_sel = s (0 to 7) stores cfg_wdata[2:0] as the level of vector {page, s}. A read with cfg_sel = s returns that level in bits 2:0, with bits 7:3 at 0.
- R4: A slot write changes the level of exactly one vector, the one selected by the current page. All other levels keep their values.
- R5: Writes with cfg_sel from 9 to 15 change nothing, and reads with those codes return 0.
- R6: The winner is the pending vector with the highest nonzero level, where a larger number means more urgent.
- R7: A vector at level 0 never wins, even while it is pending. When no pending vector has a nonzero level, irq_vec and irq_lvl are 0.
- R8: When several pending vectors share the highest level, the one with the larger vector number wins.
- R9: irq_req is 1 exactly when the winner's level is strictly greater than cur_lvl.
- R10: irq_vec, irq_lvl and irq_req are registered. They reflect irq_pend, cur_lvl and the level table as they stood at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pend | input | 128 | One pending flag per vector |
| cur_lvl | input | 3 | Level of the code now running; masks requests at or below it |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register select: 0-7 slot, 8 page, 9-15 unused |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| irq_req | output | 1 | Winner is above cur_lvl |
| irq_vec | output | 7 | Winning vector number |
| irq_lvl | output | 3 | Winning level |

## Verification
Every vector's level is read back through all sixteen pages. Page writes carry junk in bits 7 and 2:0, and slot writes carry junk in bits 7:3. A design that decoded the page from the wrong bits, or stored those junk bits, would place levels on the wrong vectors or return nonzero upper bits.

Each vector is raised alone, and after that many scattered pending patterns are applied while cur_lvl is swept. This exposes a tree that loses a leaf, compares levels the wrong way, or treats the mask as "greater or equal".

With all levels equal and every line pending, vector 127 must win. A design with the tie-break reversed would return 0 instead. Setting that vector to level 0 must hand the win to 126, and raising it alone must produce no request and a zero vector. A block that ignores the disable would wrongly report it.

A level change made while the pending lines stay fixed is checked one edge late. This catches an output path that is combinational, or one that is delayed by an extra stage.

// File: rtl/irq_arb_pkg.sv
// Package: shared register-select codes for the paged interrupt arbiter.
// Assumes a 4-bit select bus where codes below the window size address slots.
package irq_arb_pkg;
    localparam int ARB_SEL_W  = 4;
    localparam int ARB_DATA_W = 8;
    // Select code of the page register; slot codes run from 0 to window size - 1.
    localparam logic [ARB_SEL_W-1:0] SEL_PAGE = 4'd8;
endpackage

// File: rtl/irq_cfg_regs.sv
// Module: irq_cfg_regs
// Holds the page register and the per-vector priority table, and maps the
// slot registers onto the vectors of the selected page.
// Assumes NUM_VEC and WIN_SZ are powers of two, WIN_SZ < NUM_VEC, and
// PRIO_W <= $clog2(WIN_SZ) <= DATA_W. Read data is combinational.
module irq_cfg_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_VEC = 128,
    parameter int WIN_SZ  = 8,
    parameter int PRIO_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ARB_SEL_W-1:0]        cfg_sel,
    input  logic [ARB_DATA_W-1:0]       cfg_wdata,
    output logic [ARB_DATA_W-1:0]       cfg_rdata,
    output logic [NUM_VEC*PRIO_W-1:0]   prio_flat
);
    localparam int VEC_W  = $clog2(NUM_VEC);
    localparam int SLOT_W = $clog2(WIN_SZ);
    localparam int PAGE_W = VEC_W - SLOT_W;
    localparam logic [ARB_SEL_W-1:0] SEL_LAST_SLOT = ARB_SEL_W'(WIN_SZ - 1);

    logic [PAGE_W-1:0] page_q;
    logic              slot_hit;
    logic [VEC_W-1:0]  tgt_vec;
    logic              unused_wbits;

    assign slot_hit     = (cfg_sel <= SEL_LAST_SLOT);
    assign tgt_vec      = {page_q, cfg_sel[SLOT_W-1:0]};
    assign unused_wbits = ^cfg_wdata[ARB_DATA_W-1:VEC_W];

    // Page register: keeps the upper vector bits, drops the slot bits of the write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (cfg_we && cfg_sel == SEL_PAGE)
            page_q <= cfg_wdata[VEC_W-1:SLOT_W];
    end

    // One level register per vector, written only when the page and slot select it.
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic [PRIO_W-1:0] lvl_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q <= PRIO_W'(1);
            else if (cfg_we && slot_hit && tgt_vec == VEC_W'(v))
                lvl_q <= cfg_wdata[PRIO_W-1:0];
        end
        assign prio_flat[v*PRIO_W +: PRIO_W] = lvl_q;
    end

    // Read mux: slot level, page value, or zero for unused codes.
    always_comb begin
        cfg_rdata = '0;
        if (slot_hit)
            cfg_rdata[PRIO_W-1:0] = prio_flat[tgt_vec*PRIO_W +: PRIO_W];
        else if (cfg_sel == SEL_PAGE)
            cfg_rdata[VEC_W-1:0] = {page_q, {SLOT_W{1'b0}}};
    end
endmodule

// File: rtl/irq_pick.sv
// Module: irq_pick
// Combinational binary max-tree over all vectors. A leaf carries its level
// when pending and 0 otherwise. Each node prefers its upper child on a tie,
// so equal levels resolve to the larger vector number.
// Assumes NUM_VEC is a power of two. When nothing qualifies, the level is 0
// and the vector is don't-care.
module irq_pick #(
    parameter int NUM_VEC = 128,
    parameter int PRIO_W  = 3,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0]          pend,
    input  logic [NUM_VEC*PRIO_W-1:0]   prio_flat,
    output logic [VEC_W-1:0]            win_vec,
    output logic [PRIO_W-1:0]           win_lvl
);
    localparam int NODES = 2 * NUM_VEC;

    logic [PRIO_W-1:0] nd_lvl [1:NODES-1];
    logic [VEC_W-1:0]  nd_vec [1:NODES-1];

    // Leaves: a masked level and a fixed vector number for each line.
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_leaf
        assign nd_lvl[NUM_VEC+v] = pend[v] ? prio_flat[v*PRIO_W +: PRIO_W] : '0;
        assign nd_vec[NUM_VEC+v] = VEC_W'(v);
    end

    // Inner nodes: the right child holds the higher vectors and wins ties.
    for (genvar n = 1; n < NUM_VEC; n++) begin : g_node
        logic take_hi;
        assign take_hi   = (nd_lvl[2*n+1] >= nd_lvl[2*n]);
        assign nd_lvl[n] = take_hi ? nd_lvl[2*n+1] : nd_lvl[2*n];
        assign nd_vec[n] = take_hi ? nd_vec[2*n+1] : nd_vec[2*n];
    end

    assign win_vec = nd_vec[1];
    assign win_lvl = nd_lvl[1];
endmodule

// File: rtl/irq_paged_arb.sv
// Module: irq_paged_arb (top)
// Paged priority configuration plus a registered arbitration result.
// Assumes the current-level input is synchronous to clk. Outputs lag their
// inputs by exactly one clock edge.
module irq_paged_arb
    import irq_arb_pkg::*;
#(
    parameter int NUM_VEC = 128,
    parameter int WIN_SZ  = 8,
    parameter int PRIO_W  = 3,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_VEC-1:0]      irq_pend,
    input  logic [PRIO_W-1:0]       cur_lvl,
    input  logic                    cfg_we,
    input  logic [ARB_SEL_W-1:0]    cfg_sel,
    input  logic [ARB_DATA_W-1:0]   cfg_wdata,
    output logic [ARB_DATA_W-1:0]   cfg_rdata,
    output logic                    irq_req,
    output logic [VEC_W-1:0]        irq_vec,
    output logic [PRIO_W-1:0]       irq_lvl
);
    logic [NUM_VEC*PRIO_W-1:0] prio_flat;
    logic [VEC_W-1:0]          raw_vec;
    logic [PRIO_W-1:0]         raw_lvl;

    irq_cfg_regs #(.NUM_VEC(NUM_VEC), .WIN_SZ(WIN_SZ), .PRIO_W(PRIO_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .prio_flat (prio_flat)
    );

    irq_pick #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W)) pick_i (
        .pend      (irq_pend),
        .prio_flat (prio_flat),
        .win_vec   (raw_vec),
        .win_lvl   (raw_lvl)
    );

    // Output stage: register the winner, zero the vector when no one qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_vec <= '0;
            irq_lvl <= '0;
            irq_req <= 1'b0;
        end else begin
            irq_lvl <= raw_lvl;
            irq_vec <= (raw_lvl == '0) ? '0 : raw_vec;
            irq_req <= (raw_lvl > cur_lvl);
        end
    end
endmodule

// File: rtl/irq_paged_arb_chk.sv
// Module: irq_paged_arb_chk
// Property checker bound to irq_paged_arb. It keeps its own one-cycle copies
// of the inputs, so that it can relate the registered outputs to them.
module irq_paged_arb_chk #(
    parameter int NUM_VEC = 128,
    parameter int PRIO_W  = 3,
    parameter int VEC_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_VEC-1:0] irq_pend,
    input logic [PRIO_W-1:0]  cur_lvl,
    input logic [3:0]         cfg_sel,
    input logic [7:0]         cfg_rdata,
    input logic               irq_req,
    input logic [VEC_W-1:0]   irq_vec,
    input logic [PRIO_W-1:0]  irq_lvl
);
    logic [NUM_VEC-1:0] pend_q;
    logic [PRIO_W-1:0]  cur_q;

    // Sample the inputs that the registered outputs were computed from.
    always_ff @(posedge clk) begin
        pend_q <= irq_pend;
        cur_q  <= cur_lvl;
    end

    AST_REQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (irq_lvl > cur_q)); // R9
    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl != '0) |-> pend_q[irq_vec]); // R6
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl == '0) |-> (irq_vec == '0 && !irq_req)); // R7
    AST_SLOT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel < 4'd8) |-> (cfg_rdata[7:PRIO_W] == '0)); // R3
    AST_PAGE_READ_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 4'd8) |-> (cfg_rdata[2:0] == 3'd0 && !cfg_rdata[7])); // R2
    AST_UNUSED_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel > 4'd8) |-> (cfg_rdata == 8'd0)); // R5
endmodule

bind irq_paged_arb irq_paged_arb_chk #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pend  (irq_pend),
    .cur_lvl   (cur_lvl),
    .cfg_sel   (cfg_sel),
    .cfg_rdata (cfg_rdata),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .irq_lvl   (irq_lvl)
);

// File: tb/irq_paged_arb_tb_top.sv
// Bench: sweeps the level table through the paged window and checks the
// arbitration result against a model built from the requirements.
module irq_paged_arb_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [127:0] irq_pend;
    logic [2:0]   cur_lvl;
    logic         cfg_we;
    logic [3:0]   cfg_sel;
    logic [7:0]   cfg_wdata;
    logic [7:0]   cfg_rdata;
    logic         irq_req;
    logic [6:0]   irq_vec;
    logic [2:0]   irq_lvl;

    int n_chk = 0;
    int n_err = 0;
    logic [2:0] exp_prio [128];
    logic [3:0] exp_page;

    always #2 clk = ~clk;

    irq_paged_arb dut_i (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .cur_lvl(cur_lvl),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_lvl(irq_lvl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One register write; the bench model follows the requirement text.
    task automatic cfg_write(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 4'd8) exp_page = d[6:3];
        else if (sel < 4'd8) exp_prio[{exp_page, sel[2:0]}] = d[2:0];
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] sel, input logic [7:0] exp);
        @(negedge clk);
        cfg_sel = sel;
        #1 chk(tag, 32'(cfg_rdata), 32'(exp));
    endtask

    // Read every level through all pages and compare to the model.
    task automatic sweep_levels(input string tag);
        for (int pg = 0; pg < 16; pg++) begin
            cfg_write(4'd8, {1'b1, 4'(pg), 3'b101});
            rd_chk({tag, " R2 page"}, 4'd8, {1'b0, 4'(pg), 3'b000});
            for (int s = 0; s < 8; s++)
                rd_chk({tag, " R3"}, 4'(s), {5'd0, exp_prio[pg*8+s]});
        end
    endtask

    function automatic void model(input logic [127:0] p, output logic [6:0] v, output logic [2:0] l);
        v = '0; l = '0;
        for (int i = 0; i < 128; i++)
            if (p[i] && exp_prio[i] != 3'd0 && exp_prio[i] >= l) begin
                v = 7'(i); l = exp_prio[i];
            end
    endfunction

    // Apply a pattern, wait one edge, compare the registered outputs.
    task automatic arb_chk(input string tag, input logic [127:0] p, input logic [2:0] c);
        logic [6:0] ev; logic [2:0] el;
        @(negedge clk);
        irq_pend = p; cur_lvl = c;
        @(negedge clk);
        model(p, ev, el);
        chk({tag, " vec"}, 32'(irq_vec), 32'(ev));
        chk({tag, " lvl"}, 32'(irq_lvl), 32'(el));
        chk({tag, " R9 req"}, 32'(irq_req), 32'(el > c));
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [6:0] ov; logic [2:0] ol;
        rst_n = 1'b0; irq_pend = '0; cur_lvl = '0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        exp_page = '0;
        for (int i = 0; i < 128; i++) exp_prio[i] = 3'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 req", 32'(irq_req), 0);
        chk("R1 vec", 32'(irq_vec), 0);
        chk("R1 lvl", 32'(irq_lvl), 0);
        rd_chk("R1 page", 4'd8, 8'd0);
        sweep_levels("R1");

        // R2 R3 R4: program every vector with junk bits, then read all back
        for (int pg = 0; pg < 16; pg++) begin
            cfg_write(4'd8, {1'b1, 4'(pg), 3'b111});
            for (int s = 0; s < 8; s++)
                cfg_write(4'(s), {5'b11010, 3'((pg * 8 + s) * 3 + pg)});
        end
        sweep_levels("R4");

        // R5: unused codes are inert and read as zero
        cfg_write(4'd8, 8'h28);
        cfg_write(4'd9, 8'hff);
        cfg_write(4'd15, 8'h00);
        rd_chk("R5 sel9", 4'd9, 8'd0);
        rd_chk("R5 sel15", 4'd15, 8'd0);
        rd_chk("R5 page kept", 4'd8, 8'h28);
        sweep_levels("R5");

        // R6 R7: each line alone, then scattered patterns with a swept mask
        for (int v = 0; v < 128; v++)
            arb_chk("R6 single", 128'(1) << v, 3'd0);
        for (int k = 0; k < 300; k++)
            arb_chk("R6 mix", {$urandom, $urandom, $urandom, $urandom}, 3'(k));

        // R8: equal levels everywhere, highest vector wins
        for (int pg = 0; pg < 16; pg++) begin
            cfg_write(4'd8, {1'b0, 4'(pg), 3'b000});
            for (int s = 0; s < 8; s++) cfg_write(4'(s), 8'd4);
        end
        arb_chk("R8 all", '1, 3'd0);
        chk("R8 winner", 32'(irq_vec), 127);
        arb_chk("R8 pair", (128'(1) << 5) | (128'(1) << 90), 3'd0);
        chk("R8 pair winner", 32'(irq_vec), 90);
        for (int c = 0; c < 8; c++) arb_chk("R9 sweep", '1, 3'(c));

        // R7: a disabled line loses even when pending
        cfg_write(4'd8, 8'h78);
        cfg_write(4'd7, 8'd0);
        arb_chk("R7 all", '1, 3'd0);
        chk("R7 winner", 32'(irq_vec), 126);
        arb_chk("R7 alone", 128'(1) << 127, 3'd0);
        chk("R7 none vec", 32'(irq_vec), 0);
        chk("R7 none req", 32'(irq_req), 0);

        // R10: a level change is seen exactly one edge after it is written
        arb_chk("R10 base", 128'(1) << 10 | 128'(1) << 20, 3'd0);
        ov = irq_vec; ol = irq_lvl;
        cfg_write(4'd8, 8'h08);
        cfg_write(4'd2, 8'd7);
        chk("R10 old vec", 32'(irq_vec), 32'(ov));
        chk("R10 old lvl", 32'(irq_lvl), 32'(ol));
        @(negedge clk);
        chk("R10 new vec", 32'(irq_vec), 10);
        chk("R10 new lvl", 32'(irq_lvl), 7);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule